// File: doc/BRIEF.md
# Capability-Load Page Permission Checker

This block sits in the leaf stage of an address-translation walk. For each translation it decodes the capability-load control bits of the entry's 10-bit extension field. It also flags encodings of those bits that are reserved and combines its own verdict with the verdict the walk has built so far. The verdict tells the load path what to do with a loaded capability: pass it through (PASS), strip its tag (STRIP), or raise a capability-load page fault when the loaded value carries a tag (FAULT).

A generation scheme allows pages to be marked stale. When the entry selects generation checking, its local generation bit is compared with one of two global generation bits. The page's own user bit picks which global bit is used; the privilege mode of the access plays no part. The two global bits live in a small control register, which is the only state in the block. Software at supervisor level or above can write the register. Writes from user level do not change it.

The lookup path is purely combinational and has no handshake: one entry is judged per cycle, and the result is valid in the same cycle as its inputs. The control register is a plain write port with no back-pressure. A write takes effect on the clock edge that accepts it.

Top module: `ptw_capload_gate`

## Requirements
- R1: After reset the control register reads 0 in both generation bits, reads 1 in bit 1 and bit 0, and reads 0 in every other bit.
- R2: A write with `ctl_wr_priv` not equal to 0 copies write-data bit 3 into the user generation bit and write-data bit 2 into the supervisor generation bit. The new values are visible on `ctl_rd_data` from the next cycle. Bits 1 and 0 still read 1 and all other bits still read 0.
- R3: A write with `ctl_wr_priv` equal to 0 (user level) leaves the whole register value unchanged.
- R4: The load-control bits are CapRead = extension bit 8, Mod = bit 6 and Gen = bit 5. The verdict encodings are PASS = 2'b00, STRIP = 2'b01 and FAULT = 2'b10. The new verdict for each combination is:
  - CapRead=0, Mod=0, Gen=0 gives STRIP.
  - CapRead=0, Mod=1, Gen=0 gives FAULT.
  - CapRead=1, Mod=0, Gen=0 gives PASS.
- R5: With CapRead=1 and Mod=1, the new verdict is PASS when Gen equals the selected global bit, and FAULT when it does not. The selected global bit is the user generation bit (register bit 3) when `pte_u`=1, and the supervisor generation bit (bit 2) when `pte_u`=0.
- R6: `pte_invalid` is 1 exactly when any of these holds:
  - `pte_v`=0.
  - `pte_w`=1 and `pte_r`=0.
  - CapRead=0 and Gen=1.
  - CapRead=1, Gen=1 and Mod=0.
- R7: The reserved encodings (CapRead=0 with Gen=1, and CapRead=1 with Mod=0 and Gen=1) give a new verdict of FAULT.
- R8: When the check applies, the output is the most severe of the prior and new verdicts, ranked PASS < STRIP < FAULT. A prior code of 2'b11 ranks as FAULT.
- R9: The check applies only when `acc_rd`=1 and `acc_cap`=1. For every other access, `verdict_out` equals `prior_verdict` unchanged.
- R10: When `ext_absent`=1, `ext_bits` is ignored and the field is taken as CapWrite=1, CapRead=1, CapDirty=1, with Mod and Gen both 0.
- R11: Extension bits 9, 7 and 4 to 0 have no effect on either output.
- R12: A lookup in the same cycle as a register write uses the register value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_bits | input | 10 | Extension field of the leaf entry |
| ext_absent | input | 1 | Translation mode has no extension field; use the default |
| pte_v | input | 1 | Entry valid bit |
| pte_r | input | 1 | Entry read-permission bit |
| pte_w | input | 1 | Entry write-permission bit |
| pte_u | input | 1 | Entry user-page bit |
| acc_rd | input | 1 | Access reads memory |
| acc_wr | input | 1 | Access writes memory |
| acc_cap | input | 1 | Access is of capability kind |
| prior_verdict | input | 2 | Verdict accumulated so far |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_priv | input | 2 | Privilege of the writer, 0 = user |
| ctl_wr_data | input | XLEN | Control register write data |
| ctl_rd_data | output | XLEN | Control register value |
| pte_invalid | output | 1 | Entry is malformed; raise a page fault |
| verdict_out | output | 2 | Merged verdict |

## Verification
A register write and a lookup that depends on the bit being written can occur in the same cycle. To provoke this, the bench drives a supervisor write that flips the user generation bit while it presents a generation-checked user page whose local bit matches only the new value. It judges that the verdict before the edge is FAULT, which matches the old register value, and that the verdict after the edge is PASS. The merge and the reserved-encoding detection also share each cycle. A full sweep of every load-control bit pattern, every prior verdict, every access kind and every global bit setting checks both outputs together.

// File: rtl/capld_pkg.sv
package capld_pkg;
  typedef enum logic [1:0] {
    VERD_PASS  = 2'b00,
    VERD_STRIP = 2'b01,
    VERD_FAULT = 2'b10
  } verdict_e;

  localparam int EXT_W   = 10;
  localparam int CR_POS  = 8;
  localparam int MOD_POS = 6;
  localparam int GEN_POS = 5;
  localparam logic [EXT_W-1:0] EXT_DEFAULT = 10'b1110000000;
endpackage

// File: rtl/capld_ctl_reg.sv
module capld_ctl_reg #(
  parameter int XLEN     = 64,
  parameter int UGEN_POS = 3,
  parameter int SGEN_POS = 2,
  parameter int PRIV_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PRIV_W-1:0] wr_priv,
  input  logic [XLEN-1:0]   wr_data,
  output logic [XLEN-1:0]   rd_data,
  output logic              ugen,
  output logic              sgen
);
  localparam int FIXED_ONES = 2;

  logic ugen_q, sgen_q;
  logic priv_ok;
  logic unused_wr;

  assign priv_ok   = (wr_priv != '0);
  assign unused_wr = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ugen_q <= 1'b0;
      sgen_q <= 1'b0;
    end else if (wr_en && priv_ok) begin
      ugen_q <= wr_data[UGEN_POS];
      sgen_q <= wr_data[SGEN_POS];
    end
  end

  for (genvar b = 0; b < XLEN; b++) begin : g_rd
    if (b < FIXED_ONES) begin : g_one
      assign rd_data[b] = 1'b1;
    end else if (b == UGEN_POS) begin : g_u
      assign rd_data[b] = ugen_q;
    end else if (b == SGEN_POS) begin : g_s
      assign rd_data[b] = sgen_q;
    end else begin : g_zero
      assign rd_data[b] = 1'b0;
    end
  end

  assign ugen = ugen_q;
  assign sgen = sgen_q;
endmodule

// File: rtl/capld_decode.sv
module capld_decode
  import capld_pkg::*;
(
  input  logic [EXT_W-1:0] ext,
  input  logic             pte_v,
  input  logic             pte_r,
  input  logic             pte_w,
  input  logic             pte_u,
  input  logic             ugen,
  input  logic             sgen,
  output verdict_e         fresh,
  output logic             invalid
);
  logic cr, md, gn, glob;
  logic base_bad, ext_bad;
  logic unused_ext;

  assign cr   = ext[CR_POS];
  assign md   = ext[MOD_POS];
  assign gn   = ext[GEN_POS];
  assign glob = pte_u ? ugen : sgen;
  assign unused_ext = ^ext;

  always_comb begin
    case ({cr, md, gn})
      3'b000:         fresh = VERD_STRIP;
      3'b010:         fresh = VERD_FAULT;
      3'b100:         fresh = VERD_PASS;
      3'b110, 3'b111: fresh = (gn == glob) ? VERD_PASS : VERD_FAULT;
      default:        fresh = VERD_FAULT;
    endcase
  end

  assign base_bad = !pte_v || (pte_w && !pte_r);
  assign ext_bad  = gn && (!cr || !md);
  assign invalid  = base_bad || ext_bad;
endmodule

// File: rtl/capld_merge.sv
module capld_merge
  import capld_pkg::*;
(
  input  logic       apply,
  input  logic [1:0] prior,
  input  verdict_e   fresh,
  output logic [1:0] merged
);
  logic any_fault, any_strip;

  assign any_fault = prior[1] || (fresh == VERD_FAULT);
  assign any_strip = (prior == 2'b01) || (fresh == VERD_STRIP);

  always_comb begin
    if (!apply)         merged = prior;
    else if (any_fault) merged = VERD_FAULT;
    else if (any_strip) merged = VERD_STRIP;
    else                merged = VERD_PASS;
  end
endmodule

// File: rtl/ptw_capload_gate.sv
module ptw_capload_gate
  import capld_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [9:0]      ext_bits,
  input  logic            ext_absent,
  input  logic            pte_v,
  input  logic            pte_r,
  input  logic            pte_w,
  input  logic            pte_u,
  input  logic            acc_rd,
  input  logic            acc_wr,
  input  logic            acc_cap,
  input  logic [1:0]      prior_verdict,
  input  logic            ctl_wr_en,
  input  logic [1:0]      ctl_wr_priv,
  input  logic [XLEN-1:0] ctl_wr_data,
  output logic [XLEN-1:0] ctl_rd_data,
  output logic            pte_invalid,
  output logic [1:0]      verdict_out
);
  logic [EXT_W-1:0] ext_eff;
  logic             ugen, sgen;
  verdict_e         fresh;
  logic             apply;
  logic             unused_acc;

  assign ext_eff    = ext_absent ? EXT_DEFAULT : ext_bits;
  assign apply      = acc_rd && acc_cap;
  assign unused_acc = acc_wr;

  capld_ctl_reg #(.XLEN(XLEN), .UGEN_POS(3), .SGEN_POS(2), .PRIV_W(2)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en), .wr_priv(ctl_wr_priv),
    .wr_data(ctl_wr_data), .rd_data(ctl_rd_data), .ugen(ugen), .sgen(sgen)
  );

  capld_decode u_dec (
    .ext(ext_eff), .pte_v(pte_v), .pte_r(pte_r), .pte_w(pte_w), .pte_u(pte_u),
    .ugen(ugen), .sgen(sgen), .fresh(fresh), .invalid(pte_invalid)
  );

  capld_merge u_mrg (
    .apply(apply), .prior(prior_verdict), .fresh(fresh), .merged(verdict_out)
  );
endmodule

// File: rtl/ptw_capload_gate_chk.sv
module ptw_capload_gate_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pte_v,
  input logic            acc_rd,
  input logic            acc_cap,
  input logic [1:0]      prior_verdict,
  input logic            ctl_wr_en,
  input logic [1:0]      ctl_wr_priv,
  input logic [XLEN-1:0] ctl_wr_data,
  input logic [XLEN-1:0] ctl_rd_data,
  input logic            pte_invalid,
  input logic [1:0]      verdict_out
);
  a_r1_fixed_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd_data[1:0] == 2'b11);

  a_r2_priv_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && ctl_wr_priv != 2'b00) |=> ctl_rd_data[3:2] == $past(ctl_wr_data[3:2]));

  a_r3_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && ctl_wr_priv == 2'b00) |=> $stable(ctl_rd_data));

  a_r6_invalid_when_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !pte_v |-> pte_invalid);

  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_cap && prior_verdict[1]) |-> verdict_out == 2'b10);

  a_r8_no_downgrade: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_cap && prior_verdict == 2'b01) |-> verdict_out != 2'b00);

  a_r9_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_rd && acc_cap) |-> verdict_out == prior_verdict);
endmodule

bind ptw_capload_gate ptw_capload_gate_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pte_v(pte_v), .acc_rd(acc_rd), .acc_cap(acc_cap),
  .prior_verdict(prior_verdict), .ctl_wr_en(ctl_wr_en), .ctl_wr_priv(ctl_wr_priv),
  .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data), .pte_invalid(pte_invalid),
  .verdict_out(verdict_out)
);

// File: tb/ptw_capload_gate_bench.sv
`timescale 1ns/1ps
module ptw_capload_gate_bench;
  localparam int XLEN = 64;
  localparam int MAX_CYCLES = 150000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [9:0]      ext_bits = '0;
  logic            ext_absent = 1'b0;
  logic            pte_v = 1'b1, pte_r = 1'b1, pte_w = 1'b0, pte_u = 1'b0;
  logic            acc_rd = 1'b0, acc_wr = 1'b0, acc_cap = 1'b0;
  logic [1:0]      prior_verdict = 2'b00;
  logic            ctl_wr_en = 1'b0;
  logic [1:0]      ctl_wr_priv = 2'b00;
  logic [XLEN-1:0] ctl_wr_data = '0;
  logic [XLEN-1:0] ctl_rd_data;
  logic            pte_invalid;
  logic [1:0]      verdict_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ptw_capload_gate #(.XLEN(XLEN)) u_ptw_capload_gate (
    .clk(clk), .rst_n(rst_n), .ext_bits(ext_bits), .ext_absent(ext_absent),
    .pte_v(pte_v), .pte_r(pte_r), .pte_w(pte_w), .pte_u(pte_u),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_cap(acc_cap),
    .prior_verdict(prior_verdict), .ctl_wr_en(ctl_wr_en), .ctl_wr_priv(ctl_wr_priv),
    .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
    .pte_invalid(pte_invalid), .verdict_out(verdict_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic [1:0] priv, input logic [XLEN-1:0] data);
    @(negedge clk);
    ctl_wr_en = 1'b1; ctl_wr_priv = priv; ctl_wr_data = data;
    @(negedge clk);
    ctl_wr_en = 1'b0;
  endtask

  function automatic int rank(input logic [1:0] v);
    return (v == 2'b00) ? 0 : (v == 2'b01) ? 1 : 2;
  endfunction

  initial begin
    #(MAX_CYCLES * 20);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset value
    check("R1 reset value", ctl_rd_data, 64'h3);

    // R2 supervisor write sets both bits; other bits ignored
    ctl_write(2'b01, {XLEN{1'b1}});
    check("R2 write all ones", ctl_rd_data, 64'hF);
    // R3 user write ignored
    ctl_write(2'b00, '0);
    check("R3 user write ignored", ctl_rd_data, 64'hF);
    ctl_write(2'b11, 64'h4);
    check("R2 write sgen only", ctl_rd_data, 64'h7);
    ctl_write(2'b00, 64'h8);
    check("R3 user write ignored again", ctl_rd_data, 64'h7);
    ctl_write(2'b10, 64'h0);
    check("R2 clear both, low bits stay one", ctl_rd_data, 64'h3);

    // R12 write and dependent lookup in the same cycle
    @(negedge clk);
    ext_absent = 1'b0; ext_bits = 10'b0101100000; // CR=1 Mod=1 Gen=1
    pte_u = 1'b1; pte_v = 1'b1; pte_r = 1'b1; pte_w = 1'b0;
    acc_rd = 1'b1; acc_cap = 1'b1; acc_wr = 1'b0; prior_verdict = 2'b00;
    ctl_wr_en = 1'b1; ctl_wr_priv = 2'b01; ctl_wr_data = 64'h8;
    #5;
    check("R12 lookup sees old generation", {62'b0, verdict_out}, 64'd2);
    @(negedge clk);
    ctl_wr_en = 1'b0;
    #5;
    check("R12 lookup sees new generation", {62'b0, verdict_out}, 64'd0);
    check("R2 user gen bit set", ctl_rd_data, 64'hB);

    // Full sweep: R4 R5 R6 R7 R8 R9 R10 R11
    for (int g = 0; g < 4; g++) begin
      ctl_write(2'b01, XLEN'(g << 2));
      for (int idx = 0; idx < 8192; idx++) begin
        logic ab, cr, md, gn, u, v, r, w, rd, wr, cp, glob, app, inv_e;
        logic [1:0] pr, fresh, exp_v;
        logic [9:0] e;
        ab = idx[0]; cr = idx[1]; md = idx[2]; gn = idx[3]; u = idx[4];
        pr = idx[6:5]; rd = idx[7]; wr = idx[8]; cp = idx[9];
        v = idx[10]; r = idx[11]; w = idx[12];
        e = 10'(idx * 37 + g * 5);
        e[8] = cr; e[6] = md; e[5] = gn;
        @(negedge clk);
        ext_absent = ab; ext_bits = e; pte_u = u; pte_v = v; pte_r = r; pte_w = w;
        acc_rd = rd; acc_wr = wr; acc_cap = cp; prior_verdict = pr;
        if (ab) begin cr = 1'b1; md = 1'b0; gn = 1'b0; end
        glob = u ? g[1] : g[0];
        if (!cr && !md && !gn)      fresh = 2'b01;
        else if (!cr && md && !gn)  fresh = 2'b10;
        else if (cr && !md && !gn)  fresh = 2'b00;
        else if (cr && md)          fresh = (gn == glob) ? 2'b00 : 2'b10;
        else                        fresh = 2'b10;
        app = rd && cp;
        if (!app) exp_v = pr;
        else begin
          int m;
          m = (rank(pr) > rank(fresh)) ? rank(pr) : rank(fresh);
          exp_v = 2'(m);
        end
        inv_e = !v || (w && !r) || (!cr && gn) || (cr && gn && !md);
        #5;
        check("R6 R10 R11 invalid flag", {63'b0, pte_invalid}, {63'b0, inv_e});
        check("R4 R5 R7 R8 R9 merged verdict", {62'b0, verdict_out}, {62'b0, exp_v});
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule